// File: doc/BRIEF.md
# Watchdog and Supply Reset Supervisor

This block drives the system reset from two causes: a supply-good flag from an external voltage comparator, and a watchdog that the host keeps alive by pulling the shared chip-select line low. Whenever either cause fires, the block asserts reset and holds it for a fixed hold time. It releases reset only after that time has passed with no new cause. All durations are counted in clock ticks set by parameters, so one tick can stand for one millisecond or for any other unit.

The watchdog period comes from a two-bit select. Three codes pick a long, a medium or a short period. The fourth code turns the watchdog off and is the power-up default. Only a high-to-low edge on the chip-select line restarts the count. That line and the supply flag each pass through a two-flop synchroniser before they are used. While reset is asserted, a busy flag tells the neighbouring memory controller to refuse every read and write command. A parameter chooses whether the reset output is active low or active high.

Top module: `rsv_supervisor`

## Requirements
- R1: While `rst_ni` is low, `busy_o` is 1 and the reset output is asserted.
- R2: After `supply_ok_i` rises and then stays high, `busy_o` falls exactly HOLD_TICKS+2 clock edges after the rise. This includes two edges of synchronisation.
- R3: A supply-low pulse of one clock, arriving while the block is running, asserts `busy_o` two edges after the pulse ends. The full hold time then restarts and runs from the end of the pulse.
- R4: When `supply_ok_i` falls, `busy_o` rises on the third clock edge and stays high for as long as the supply is low.
- R5: With `wd_sel_i` = 2'b11 the watchdog is off, and no reset occurs however long the chip-select line stays idle.
- R6: Watchdog period codes on `wd_sel_i` are 2'b00 = PERIOD_LONG, 2'b01 = PERIOD_MID and 2'b10 = PERIOD_SHORT. With no further restart, `busy_o` rises period+4 edges after a falling edge on `wdi_i`.
- R7: Only a high-to-low edge on `wdi_i` restarts the watchdog. A rising edge, or a level held steady, does not restart it.
- R8: A watchdog expiry holds reset for exactly HOLD_TICKS edges. The watchdog then counts again from zero, so with no restart the next expiry shows `busy_o` low for period+1 edges.
- R9: A change of `wd_sel_i` restarts the watchdog. `busy_o` rises new_period+2 edges after the change.
- R10: `busy_o` is high exactly while reset is asserted. `sys_rst_o` equals `~busy_o` when ACTIVE_LOW=1 and equals `busy_o` when ACTIVE_LOW=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| supply_ok_i | input | 1 | Supply-good flag from the external comparator |
| wdi_i | input | 1 | Shared chip-select / watchdog restart line |
| wd_sel_i | input | 2 | Watchdog period select (11 = off) |
| sys_rst_o | output | 1 | System reset, polarity set by ACTIVE_LOW |
| busy_o | output | 1 | High while in reset; memory commands must be refused |

## Verification
The assertions check four properties on every cycle. A supply that stays low keeps reset asserted. A release never happens unless the supply was good in the cycles before it. No reset pulse is shorter than the hold time. An expiry always leads to reset, and the disabled code never produces one. The exact latencies can only be shown by the bench scenarios: expiry for each period code, glitch restart of the hold time, the fact that a rising edge or a steady level leaves the count running, the restart on a select change, and the spacing between repeated expiries. The bench also checks both output polarities side by side.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;
endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/rsv_wdog.sv
module rsv_wdog
  import rsv_pkg::*;
#(
  parameter int PERIOD_LONG  = 1400,
  parameter int PERIOD_MID   = 600,
  parameter int PERIOD_SHORT = 200
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    kick_i,
  input  logic    hold_i,
  input  wd_sel_e sel_i,
  output logic    expire_o
);
  localparam int MAXP = (PERIOD_LONG > PERIOD_MID)
                        ? ((PERIOD_LONG > PERIOD_SHORT) ? PERIOD_LONG : PERIOD_SHORT)
                        : ((PERIOD_MID > PERIOD_SHORT) ? PERIOD_MID : PERIOD_SHORT);
  localparam int CW = $clog2(MAXP + 1);

  wd_sel_e       sel_q;
  logic [CW-1:0] cnt_q, lim;
  logic          restart;

  always_comb begin
    case (sel_i)
      WD_LONG:  lim = CW'(PERIOD_LONG);
      WD_MID:   lim = CW'(PERIOD_MID);
      WD_SHORT: lim = CW'(PERIOD_SHORT);
      default:  lim = CW'(PERIOD_LONG);
    endcase
  end

  // any of these starts the period over from zero
  assign restart = kick_i || hold_i || (sel_i != sel_q) || (sel_i == WD_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= WD_OFF;
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else begin
      sel_q <= sel_i;
      if (restart) begin
        cnt_q    <= '0;
        expire_o <= 1'b0;
      end else if (cnt_q == lim - CW'(1)) begin
        cnt_q    <= '0;
        expire_o <= 1'b1;
      end else begin
        cnt_q    <= cnt_q + CW'(1);
        expire_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rsv_hold.sv
module rsv_hold #(
  parameter int HOLD_TICKS = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic active_o
);
  localparam int HW = $clog2(HOLD_TICKS + 1);

  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b1;
      cnt_q    <= '0;
    end else if (trig_i) begin
      active_o <= 1'b1;
      cnt_q    <= '0;
    end else if (active_o) begin
      if (cnt_q == HW'(HOLD_TICKS - 1)) begin
        active_o <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + HW'(1);
      end
    end
  end
endmodule

// File: rtl/rsv_supervisor.sv
module rsv_supervisor
  import rsv_pkg::*;
#(
  parameter int HOLD_TICKS   = 200,
  parameter int PERIOD_LONG  = 1400,
  parameter int PERIOD_MID   = 600,
  parameter int PERIOD_SHORT = 200,
  parameter bit ACTIVE_LOW   = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       supply_ok_i,
  input  logic       wdi_i,
  input  logic [1:0] wd_sel_i,
  output logic       sys_rst_o,
  output logic       busy_o
);
  logic [1:0] sync_q;
  logic       wdi_d_q, wd_kick, wd_expire, in_rst, hold_trig;

  // bit 1: supply flag (resets to "bad"), bit 0: restart line (idles high)
  rsv_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({supply_ok_i, wdi_i}),
    .q_o   (sync_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wdi_d_q <= 1'b1;
    else         wdi_d_q <= sync_q[0];
  end

  assign wd_kick = wdi_d_q & ~sync_q[0];

  rsv_wdog #(
    .PERIOD_LONG (PERIOD_LONG),
    .PERIOD_MID  (PERIOD_MID),
    .PERIOD_SHORT(PERIOD_SHORT)
  ) u_wdog (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .kick_i  (wd_kick),
    .hold_i  (in_rst),
    .sel_i   (wd_sel_e'(wd_sel_i)),
    .expire_o(wd_expire)
  );

  assign hold_trig = ~sync_q[1] | wd_expire;

  rsv_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (hold_trig),
    .active_o(in_rst)
  );

  assign busy_o = in_rst;

  generate
    if (ACTIVE_LOW) begin : g_rst_low
      assign sys_rst_o = ~in_rst;
    end else begin : g_rst_high
      assign sys_rst_o = in_rst;
    end
  endgenerate
endmodule

// File: rtl/rsv_supervisor_chk.sv
module rsv_supervisor_chk #(
  parameter int HOLD_TICKS = 200
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       supply_ok_i,
  input logic [1:0] wd_sel_i,
  input logic       busy_o,
  input logic       wd_expire
);
  logic [31:0] busy_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_run <= '0;
    else if (busy_o) busy_run <= busy_run + 32'd1;
    else             busy_run <= '0;
  end

  AST_SUPPLY_LOW_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!supply_ok_i && !$past(supply_ok_i) && !$past(supply_ok_i, 2)) |=> busy_o); // R4

  AST_RELEASE_NEEDS_SUPPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(supply_ok_i, 3) && $past(supply_ok_i, 4))); // R2

  AST_HOLD_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_run >= 32'(HOLD_TICKS))); // R8

  AST_EXPIRE_RESETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_expire |=> busy_o); // R6

  AST_OFF_NO_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_sel_i == 2'b11 && $past(wd_sel_i) == 2'b11) |-> !wd_expire); // R5
endmodule

bind rsv_supervisor rsv_supervisor_chk #(.HOLD_TICKS(HOLD_TICKS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .supply_ok_i(supply_ok_i),
  .wd_sel_i   (wd_sel_i),
  .busy_o     (busy_o),
  .wd_expire  (wd_expire)
);

// File: tb/rsv_supervisor_tb_top.sv
`timescale 1ns/1ps
module rsv_supervisor_tb_top;
  localparam int HOLD  = 16;
  localparam int PLONG = 120;
  localparam int PMID  = 60;
  localparam int PSHRT = 30;
  localparam int WATCHDOG_CYCLES = 100000;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       supply_ok;
  logic       wdi;
  logic [1:0] wd_sel;
  logic       rst_lo, busy_lo, rst_hi, busy_hi;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #10 clk_i = ~clk_i;

  rsv_supervisor #(.HOLD_TICKS(HOLD), .PERIOD_LONG(PLONG), .PERIOD_MID(PMID),
                   .PERIOD_SHORT(PSHRT), .ACTIVE_LOW(1'b1)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .supply_ok_i(supply_ok), .wdi_i(wdi),
    .wd_sel_i(wd_sel), .sys_rst_o(rst_lo), .busy_o(busy_lo));

  rsv_supervisor #(.HOLD_TICKS(HOLD), .PERIOD_LONG(PLONG), .PERIOD_MID(PMID),
                   .PERIOD_SHORT(PSHRT), .ACTIVE_LOW(1'b0)) dut_hi_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .supply_ok_i(supply_ok), .wdi_i(wdi),
    .wd_sel_i(wd_sel), .sys_rst_o(rst_hi), .busy_o(busy_hi));

  function automatic int period_of(input logic [1:0] s);
    case (s)
      2'b00:   return PLONG;
      2'b01:   return PMID;
      2'b10:   return PSHRT;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_release();            return HOLD + 2;          endfunction
  function automatic int exp_expire(input logic [1:0] s); return period_of(s) + 4; endfunction
  function automatic int exp_gap(input logic [1:0] s);    return period_of(s) + 1; endfunction
  function automatic int exp_sel_change(input logic [1:0] s); return period_of(s) + 2; endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // R10: both polarities and the busy flag agree
  task automatic chk_pol();
    chk((rst_lo === ~busy_lo) && (rst_hi === busy_lo) && (busy_hi === busy_lo),
        "R10", {rst_lo, rst_hi, busy_hi}, {~busy_lo, busy_lo, busy_lo});
  endtask

  task automatic count_until(input logic want, input int limit, output int n);
    n = 0;
    while (busy_lo !== want && n < limit) begin
      tick();
      n++;
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc >= WATCHDOG_CYCLES) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG_CYCLES);
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    int highs;
    logic [1:0] codes [3];
    codes[0] = 2'b00; codes[1] = 2'b01; codes[2] = 2'b10;
    n = int'($urandom(32'd20240611));

    rst_ni = 1'b0; supply_ok = 1'b0; wdi = 1'b1; wd_sel = 2'b11;
    repeat (3) tick();
    // R1: reset state
    chk(busy_lo === 1'b1 && rst_lo === 1'b0 && rst_hi === 1'b1, "R1", {busy_lo, rst_lo}, 2'b10);
    chk_pol();
    rst_ni = 1'b1;
    repeat (4) tick();
    chk(busy_lo === 1'b1, "R1", busy_lo, 1);

    // R2: release after hold time
    supply_ok = 1'b1;
    count_until(1'b0, 200, n);
    chk(n == exp_release(), "R2", n, exp_release());
    chk_pol();

    // R3: one-cycle supply glitch restarts the hold
    repeat (5) tick();
    supply_ok = 1'b0; tick(); supply_ok = 1'b1;
    count_until(1'b1, 50, n);
    chk(n == 2, "R3", n, 2);
    count_until(1'b0, 200, n);
    chk(n == HOLD, "R3", n, HOLD);

    // R4: supply drop
    repeat (5) tick();
    supply_ok = 1'b0;
    count_until(1'b1, 50, n);
    chk(n == 3, "R4", n, 3);
    chk_pol();
    repeat (3 * HOLD) tick();
    chk(busy_lo === 1'b1, "R4", busy_lo, 1);
    supply_ok = 1'b1;
    count_until(1'b0, 200, n);
    chk(n == exp_release(), "R2", n, exp_release());

    // R5: watchdog off, line idle
    highs = 0;
    for (int i = 0; i < 3 * PLONG; i++) begin
      tick();
      if (busy_lo) highs++;
    end
    chk(highs == 0, "R5", highs, 0);

    // R6 / R8: each period code, line held low after the restart edge
    foreach (codes[k]) begin
      wd_sel = codes[k];
      repeat (3) tick();
      wdi = 1'b0;
      count_until(1'b1, 1000, n);
      chk(n == exp_expire(codes[k]), "R6", n, exp_expire(codes[k]));
      chk_pol();
      count_until(1'b0, 1000, n);
      chk(n == HOLD, "R8", n, HOLD);
      count_until(1'b1, 1000, n);
      chk(n == exp_gap(codes[k]), "R8", n, exp_gap(codes[k]));
      count_until(1'b0, 1000, n);
      wd_sel = 2'b11;
      wdi = 1'b1;
      repeat (3) tick();
    end

    // R7: rising edge does not restart
    wd_sel = 2'b10;
    repeat (3) tick();
    wdi = 1'b0;
    repeat (PSHRT / 2) tick();
    wdi = 1'b1;
    count_until(1'b1, 1000, n);
    chk(n == exp_expire(2'b10) - PSHRT / 2, "R7", n, exp_expire(2'b10) - PSHRT / 2);
    count_until(1'b0, 1000, n);

    // R7: random restart edges keep reset away
    wd_sel = 2'b01;
    highs = 0;
    for (int i = 0; i < 16; i++) begin
      int gap;
      gap = int'($urandom_range(PMID - 10, 8));
      wdi = 1'b0; tick(); if (busy_lo) highs++;
      tick(); if (busy_lo) highs++;
      wdi = 1'b1;
      for (int j = 2; j < gap; j++) begin
        tick();
        if (busy_lo) highs++;
      end
    end
    chk(highs == 0, "R7", highs, 0);
    wdi = 1'b0;
    count_until(1'b1, 1000, n);
    chk(n == exp_expire(2'b01), "R6", n, exp_expire(2'b01));
    count_until(1'b0, 1000, n);
    wdi = 1'b1;

    // R9: select change restarts the count
    repeat (PMID - 6) tick();
    chk(busy_lo === 1'b0, "R9", busy_lo, 0);
    wd_sel = 2'b10;
    count_until(1'b1, 1000, n);
    chk(n == exp_sel_change(2'b10), "R9", n, exp_sel_change(2'b10));
    chk_pol();
    count_until(1'b0, 1000, n);
    chk_pol();

    summary();
    $finish;
  end
endmodule